// File: doc/BRIEF.md
# Bus Master Access Gate

This block sits next to a system bus and decides, for every access, whether the requesting master may reach the targeted peripheral or memory region. Each of `NUM_REGIONS` regions owns an 8-bit permission word. Half of that word enables individual bus masters: core 0, core 1, the DMA engine and the debugger. The other half grants access per security and privilege level. A request is allowed only when both the master's enable bit and the grant for the request's level are set. The allow decision is combinational from the request and the current register state.

The configuration is written through a small register port, and every write carries the ID of the master that issued it. A per-master lock register makes the gate quietly drop all later writes from a master once that master's lock bit is set. The DMA engine starts out locked. A force bit can make every access from core 1 count as non-secure. A write-one reset command restores every permission word to its default and leaves the lock and force settings as they are. Each region's default is picked from four classes through the `REGION_CLASS` parameter, two bits per region. Class 0 is open (0xFF), class 1 is secure from any master (0xFC), class 2 is secure privileged (0xF8), and class 3 is secure privileged from a processor or the debugger (0xB8).

Top module: `bus_access_gate`

## Requirements
- R1: After reset, the lock register (address 0) reads 0x04. The force register (address 1) reads 0x00. Each region word at address 16+i reads its class default: class 0 is 0xFF, class 1 is 0xFC, class 2 is 0xF8, class 3 is 0xB8.
- R2: Master IDs are 0 core 0, 1 core 1, 2 DMA and 3 debugger. Lock bit k belongs to master k. A write from a master whose lock bit is 1 changes no register.
- R3: A write to address 0 ORs data bits [3:0] into the lock bits. A lock bit that is 1 never returns to 0 until system reset.
- R4: An accepted write becomes visible on read data and on the allow decision in the cycle after the write edge. The allow output follows request inputs within the same cycle.
- R5: A request is allowed only if bit 4+master of the target region word is 1 and the grant for the request's level is met.
- R6: A secure privileged request needs bit 3. A secure unprivileged request needs both bit 2 and bit 3.
- R7: A non-secure privileged request needs bit 1. A non-secure unprivileged request needs both bit 0 and bit 1.
- R8: When bit 1 of the force register (address 1) is 1, every request from core 1 is judged as non-secure. Requests from other masters are not affected.
- R9: Writing data bit 0 = 1 to address 2 restores every region word to its default. Lock and force are unchanged. Address 2 always reads 0x00.
- R10: A request whose region index is NUM_REGIONS or higher is denied. Reads from unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_master | input | 2 | Master ID of the writer |
| cfg_addr | input | CFG_AW | Register word address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| req_master | input | 2 | Master ID of the bus access |
| req_secure | input | 1 | 1 for a secure access |
| req_priv | input | 1 | 1 for a privileged access |
| req_region | input | $clog2(NUM_REGIONS)+1 | Target region index |
| req_allow | output | 1 | 1 when the access is permitted |

## Verification
On every cycle, the assertions check the following:
- Lock bits never fall.
- A write from a locked master or to an unmapped address leaves the state unchanged.
- The reset command keeps the lock and force settings.
- An allowed access always has its master enable bit set and the privileged grant set for its level.
- A forced core 1 access is only allowed under the non-secure privileged grant.
- An out-of-range region is never allowed.

Only the bench's scenarios can show the following:
- The exact default words per class.
- That the reset command really restores them.
- The one-cycle write latency.
- The precise allow value for every mix of master, level and word.

For these, the bench compares against its own model across random traffic and directed corners.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        MST_CORE0 = 2'd0,
        MST_CORE1 = 2'd1,
        MST_DMA   = 2'd2,
        MST_DEBUG = 2'd3
    } master_e;

    // Bit positions inside a permission word
    localparam int BIT_NS_USER = 0;
    localparam int BIT_NS_PRIV = 1;
    localparam int BIT_S_USER  = 2;
    localparam int BIT_S_PRIV  = 3;
    localparam int BIT_EN_BASE = 4;

    // Register word addresses
    localparam int ADR_LOCK    = 0;
    localparam int ADR_FORCE   = 1;
    localparam int ADR_RESTORE = 2;
    localparam int ADR_REGION0 = 16;

    localparam logic [3:0] LOCK_RESET = 4'b0100;

    function automatic logic [7:0] class_word(input logic [1:0] cls);
        case (cls)
            2'd0:    class_word = 8'hFF;
            2'd1:    class_word = 8'hFC;
            2'd2:    class_word = 8'hF8;
            default: class_word = 8'hB8;
        endcase
    endfunction

endpackage

// File: rtl/gate_regs.sv
module gate_regs
    import gate_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter logic [2*NUM_REGIONS-1:0] REGION_CLASS = '0,
    parameter int CFG_AW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_master,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    output logic [7:0]                  cfg_rdata,
    output logic [3:0]                  lock_q,
    output logic                        force_q,
    output logic [NUM_REGIONS-1:0][7:0] perm_q
);

    localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    typedef struct packed {
        logic [3:0]                  lock;
        logic                        force_c1;
        logic [NUM_REGIONS-1:0][7:0] perm;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_REGIONS-1:0][7:0] dflt;
    logic [CFG_AW-1:0] reg_off;
    logic              reg_hit;
    logic              wr_ok;

    always_comb begin
        for (int i = 0; i < NUM_REGIONS; i++) begin
            dflt[i] = class_word(REGION_CLASS[2*i +: 2]);
        end
    end

    always_comb begin
        reg_off = cfg_addr - CFG_AW'(ADR_REGION0);
        reg_hit = (int'(cfg_addr) >= ADR_REGION0) && (int'(reg_off) < NUM_REGIONS);
        wr_ok   = cfg_we && !st_q.lock[cfg_master];
    end

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            if (int'(cfg_addr) == ADR_LOCK) begin
                st_d.lock = st_q.lock | cfg_wdata[3:0];
            end else if (int'(cfg_addr) == ADR_FORCE) begin
                st_d.force_c1 = cfg_wdata[1];
            end else if (int'(cfg_addr) == ADR_RESTORE) begin
                if (cfg_wdata[0]) st_d.perm = dflt;
            end else if (reg_hit) begin
                st_d.perm[reg_off[IW-1:0]] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock     <= LOCK_RESET;
            st_q.force_c1 <= 1'b0;
            st_q.perm     <= dflt;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (int'(cfg_addr) == ADR_LOCK) begin
            cfg_rdata = {4'h0, st_q.lock};
        end else if (int'(cfg_addr) == ADR_FORCE) begin
            cfg_rdata = {6'h0, st_q.force_c1, 1'b0};
        end else if (reg_hit) begin
            cfg_rdata = st_q.perm[reg_off[IW-1:0]];
        end
    end

    assign lock_q  = st_q.lock;
    assign force_q = st_q.force_c1;
    assign perm_q  = st_q.perm;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_q & $past(lock_q)) == $past(lock_q))); // R3

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock_q[cfg_master]) |=> ($stable(perm_q) && $stable(force_q) && $stable(lock_q))); // R2

    AST_RESTORE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) == ADR_RESTORE) |=> ($stable(lock_q) && $stable(force_q))); // R9

    AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && int'(cfg_addr) > ADR_RESTORE && int'(cfg_addr) < ADR_REGION0)
        |=> ($stable(perm_q) && $stable(force_q) && $stable(lock_q))); // R10

endmodule

// File: rtl/gate_decode.sv
module gate_decode
    import gate_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [1:0]                       req_master,
    input  logic                             req_secure,
    input  logic                             req_priv,
    input  logic [$clog2(NUM_REGIONS):0]     req_region,
    input  logic                             force_c1,
    input  logic [NUM_REGIONS-1:0][7:0]      perm,
    output logic                             req_allow
);

    localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [7:0] word;
    logic       in_range;
    logic       eff_secure;
    logic       mst_en;
    logic       level_ok;

    always_comb begin
        in_range   = int'(req_region) < NUM_REGIONS;
        word       = perm[req_region[IW-1:0]];
        eff_secure = req_secure && !(force_c1 && req_master == MST_CORE1);
        mst_en     = word[BIT_EN_BASE + int'(req_master)];
        case ({eff_secure, req_priv})
            2'b11:   level_ok = word[BIT_S_PRIV];
            2'b10:   level_ok = word[BIT_S_PRIV] && word[BIT_S_USER];
            2'b01:   level_ok = word[BIT_NS_PRIV];
            default: level_ok = word[BIT_NS_PRIV] && word[BIT_NS_USER];
        endcase
        req_allow = in_range && mst_en && level_ok;
    end

endmodule

// File: rtl/bus_access_gate.sv
module bus_access_gate
    import gate_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter logic [2*NUM_REGIONS-1:0] REGION_CLASS = 16'h7E50,
    parameter int CFG_AW = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_master,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [7:0]                     cfg_wdata,
    output logic [7:0]                     cfg_rdata,
    input  logic [1:0]                     req_master,
    input  logic                           req_secure,
    input  logic                           req_priv,
    input  logic [$clog2(NUM_REGIONS):0]   req_region,
    output logic                           req_allow
);

    localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [3:0]                  lock_q;
    logic                        force_q;
    logic [NUM_REGIONS-1:0][7:0] perm_q;

    gate_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .REGION_CLASS(REGION_CLASS),
        .CFG_AW      (CFG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_master(cfg_master),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lock_q    (lock_q),
        .force_q   (force_q),
        .perm_q    (perm_q)
    );

    gate_decode #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_dec (
        .req_master(req_master),
        .req_secure(req_secure),
        .req_priv  (req_priv),
        .req_region(req_region),
        .force_c1  (force_q),
        .perm      (perm_q),
        .req_allow (req_allow)
    );

    AST_NEED_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_allow |-> perm_q[req_region[IW-1:0]][BIT_EN_BASE + int'(req_master)]); // R5

    AST_SEC_USER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_allow && req_secure && !req_priv && !(force_q && req_master == MST_CORE1))
        |-> perm_q[req_region[IW-1:0]][BIT_S_PRIV]); // R6

    AST_NS_USER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_allow && !req_secure && !req_priv) |-> perm_q[req_region[IW-1:0]][BIT_NS_PRIV]); // R7

    AST_FORCE_NS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_allow && force_q && req_master == MST_CORE1 && req_priv)
        |-> perm_q[req_region[IW-1:0]][BIT_NS_PRIV]); // R8

    AST_RANGE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_region) >= NUM_REGIONS) |-> !req_allow); // R10

endmodule

// File: tb/sim_bus_access_gate.sv
module sim_bus_access_gate;

    localparam int N  = 8;
    localparam logic [15:0] CLS = 16'h7E50;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_master = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [1:0] req_master = '0;
    logic req_secure = 1'b0;
    logic req_priv = 1'b0;
    logic [3:0] req_region = '0;
    logic req_allow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] m_lock;
    logic       m_force;
    logic [7:0] m_perm [N];

    always #10 clk = ~clk;

    bus_access_gate #(.NUM_REGIONS(N), .REGION_CLASS(CLS), .CFG_AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master(cfg_master),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_master(req_master), .req_secure(req_secure), .req_priv(req_priv),
        .req_region(req_region), .req_allow(req_allow)
    );

    function automatic logic [7:0] dflt(input int i);
        case (CLS[2*i +: 2])
            2'd0: return 8'hFF;
            2'd1: return 8'hFC;
            2'd2: return 8'hF8;
            default: return 8'hB8;
        endcase
    endfunction

    function automatic logic exp_allow(input logic [1:0] m, input logic s, input logic p, input int r);
        logic [7:0] w;
        logic es, lv;
        if (r >= N) return 1'b0;
        w  = m_perm[r];
        es = s && !(m_force && m == 2'd1);
        if (es && p)       lv = w[3];
        else if (es)       lv = w[3] && w[2];
        else if (p)        lv = w[1];
        else               lv = w[1] && w[0];
        return w[4 + m] && lv;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        if (a == 0) return {4'h0, m_lock};
        if (a == 1) return {6'h0, m_force, 1'b0};
        if (a >= 16 && a < 16 + N) return m_perm[a - 16];
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_lock = 4'h4;
        m_force = 1'b0;
        for (int i = 0; i < N; i++) m_perm[i] = dflt(i);
    endtask

    task automatic model_write();
        int a;
        a = int'(cfg_addr);
        if (!cfg_we || m_lock[cfg_master]) return;
        if (a == 0) m_lock = m_lock | cfg_wdata[3:0];
        else if (a == 1) m_force = cfg_wdata[1];
        else if (a == 2) begin
            if (cfg_wdata[0]) for (int i = 0; i < N; i++) m_perm[i] = dflt(i);
        end else if (a >= 16 && a < 16 + N) m_perm[a - 16] = cfg_wdata;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs mid-cycle, apply model at the edge.
    task automatic cyc(input logic we, input logic [1:0] wm, input int wa, input logic [7:0] wd,
                       input logic [1:0] rm, input logic rs, input logic rp, input int rr,
                       input string tag);
        @(negedge clk);
        cfg_we = we; cfg_master = wm; cfg_addr = AW'(wa); cfg_wdata = wd;
        req_master = rm; req_secure = rs; req_priv = rp; req_region = 4'(rr);
        #4;
        chk({tag, " allow"}, {7'h0, req_allow}, {7'h0, exp_allow(rm, rs, rp, rr)});
        chk({tag, " rdata"}, cfg_rdata, exp_read(wa));
        model_write();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 16 + N; a++) cyc(0, 0, a, 0, 0, 1, 1, 0, "R1");

        // R6 R7 R5: level matrix on each class
        for (int r = 0; r < N; r++)
            for (int k = 0; k < 16; k++)
                cyc(0, 0, 16 + r, 0, 2'(k >> 2), k[1], k[0], r, "R5 R6 R7");

        // R7: NS user needs both bits; set word with only NSU plus all enables
        cyc(1, 0, 16, 8'hF1, 0, 0, 0, 0, "R4");
        cyc(0, 0, 16, 0, 0, 0, 0, 0, "R7 nsu-only");
        cyc(1, 0, 16, 8'hF4, 0, 1, 0, 0, "R4");
        cyc(0, 0, 16, 0, 0, 1, 0, 0, "R6 su-only");
        // R5: master enable cleared for core1
        cyc(1, 0, 16, 8'hDF, 1, 1, 1, 0, "R4 before-edge");
        cyc(0, 0, 16, 0, 1, 1, 1, 0, "R5 enable off");

        // R8: force core1 non-secure
        cyc(1, 0, 17, 8'hFC, 1, 1, 1, 1, "R8 setup");
        cyc(1, 0, 1, 8'h02, 1, 1, 1, 1, "R8 pre");
        cyc(0, 0, 1, 0, 1, 1, 1, 1, "R8 forced core1");
        cyc(0, 0, 1, 0, 0, 1, 1, 1, "R8 core0 unaffected");

        // R2: DMA locked from reset, its writes dropped
        cyc(1, 2, 18, 8'h00, 0, 1, 1, 2, "R2 dma write");
        cyc(0, 0, 18, 0, 0, 1, 1, 2, "R2 dma dropped");
        cyc(1, 2, 1, 8'h00, 0, 1, 1, 2, "R2 dma force");
        cyc(0, 0, 1, 0, 0, 1, 1, 2, "R2 force kept");

        // R9: restore keeps lock and force, reads zero
        cyc(1, 3, 2, 8'h01, 0, 1, 1, 0, "R9 restore");
        for (int a = 0; a < 16 + N; a++) cyc(0, 0, a, 0, 1, 1, 1, a & 7, "R9 after");

        // R10: unmapped writes/reads, out of range region
        cyc(1, 0, 7, 8'hFF, 0, 1, 1, 8, "R10 unmapped wr");
        cyc(0, 0, 7, 0, 3, 1, 1, 15, "R10 read/range");
        cyc(1, 0, 16 + N, 8'h00, 0, 0, 0, 9, "R10 past end");

        // R3: lock core1, zero write cannot clear
        cyc(1, 1, 0, 8'h02, 1, 1, 1, 0, "R3 lock c1");
        cyc(1, 0, 0, 8'h00, 1, 1, 1, 0, "R3 zero write");
        cyc(0, 0, 0, 0, 1, 1, 1, 0, "R3 sticky");
        cyc(1, 1, 16, 8'h00, 1, 1, 1, 0, "R2 c1 locked");
        cyc(0, 0, 16, 0, 1, 1, 1, 0, "R2 c1 dropped");

        // Random traffic, lock writes rare
        for (int n = 0; n < 3000; n++) begin
            int a;
            logic we;
            we = $urandom_range(0, 1);
            a = $urandom_range(0, 31);
            if (a == 0 && $urandom_range(0, 15) != 0) a = 16;
            if (a == 2 && $urandom_range(0, 3) != 0) a = 17;
            cyc(we, 2'($urandom_range(0, 3)), a, 8'($urandom),
                2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                $urandom_range(0, 11), "R4 R5 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule